// File: doc/BRIEF.md
# Multi-Channel Commit Strobe Hub

This block coordinates atomic updates that span several peripherals. It owns a small set of transaction channels. Each channel is a single pending bit that is set and cleared through a register write. Setting the bit produces a one-cycle begin strobe and clearing it produces a one-cycle commit strobe, and both strobes go to every peripheral slot. Each slot has a channel-select register and follows only the strobes of the channel it selects. On a begin strobe the slot snapshots its live value into a read shadow, so that reads return the value as it was when the transaction opened. On a commit strobe the slot copies its staged write value into its live register. Every slot on the same channel therefore changes in one clock edge.

Software holds a transaction open across many bus writes and then closes it with one write. An optional owner register names the channel that is currently writing. Once it has been written, a staged write to a slot that listens to a different channel is refused: the write is dropped and a one-cycle fault pulse is raised. The live register of each slot can also be loaded from the peripheral side.

Top module: `txn_strobe_hub`

## Requirements
- R1: After reset every pending bit, begin strobe, commit strobe and the fault output are 0. Every live value, read shadow, staged value and channel select is 0, and the owner register is unset.
- R2: A write of 1 to the pending bit of channel c (pend_ch = c) while that bit is 0 makes start_o bit c high for exactly one cycle, the cycle after the write edge. A write of 1 while the bit is already 1 produces no begin strobe.
- R3: A write of 0 to the pending bit of a set channel makes done_o bit c high for exactly one cycle, the cycle after the write edge. A write of 0 to a clear bit produces no commit strobe.
- R4: At the edge where the selected channel's begin strobe is high, a slot copies its live value into its read shadow. rd_data shows the read shadow of slot rd_per, and later changes to the live value do not alter it.
- R5: At the edge where the selected channel's commit strobe is high, a slot copies its staged value into its live value. All slots on that channel update at the same edge.
- R6: Strobes of a channel a slot does not select leave that slot's live value and read shadow unchanged.
- R7: A write to a slot's channel select (map_we) changes which channel the slot follows from the next cycle on.
- R8: Until the owner register has been written, no staged write is refused and fault_o stays 0.
- R9: After the owner register is written, a staged write to a slot whose channel select differs from it is dropped and raises fault_o for one cycle after the write edge. A staged write to a matching slot is accepted with no fault.
- R10: A peripheral-side write (hw_we) loads the live value directly. When it meets a commit to the same slot at the same edge, the commit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_we | input | 1 | Write a channel pending bit |
| pend_ch | input | $clog2(N_CH) | Channel whose pending bit is written |
| pend_val | input | 1 | New pending bit value |
| own_we | input | 1 | Write the owner register |
| own_ch | input | $clog2(N_CH) | Owner channel value |
| map_we | input | 1 | Write a slot's channel select |
| map_per | input | $clog2(N_PER) | Slot index for channel select write |
| map_ch | input | $clog2(N_CH) | Channel select value |
| wsh_we | input | 1 | Staged write to a slot |
| wsh_per | input | $clog2(N_PER) | Slot index for staged write |
| wsh_data | input | DW | Staged write data |
| hw_we | input | 1 | Peripheral-side live write |
| hw_per | input | $clog2(N_PER) | Slot index for live write |
| hw_data | input | DW | Live write data |
| rd_per | input | $clog2(N_PER) | Slot whose read shadow is shown |
| rd_data | output | DW | Read shadow of slot rd_per |
| live_flat | output | N_PER*DW | All live values, slot p at bits p*DW |
| pend_o | output | N_CH | Pending bits |
| start_o | output | N_CH | Begin strobes |
| done_o | output | N_CH | Commit strobes |
| fault_o | output | 1 | Ownership fault pulse |

## Verification
The checker watches several properties on every cycle. Each strobe lasts one cycle and follows a set or clear of a changing pending bit. A fault always traces back to a staged write made the cycle before. Live values hold steady in any cycle with neither a commit nor a peripheral-side write. Only the bench scenarios can show that snapshots and commits land in the right slots for every slot and channel pairing, that a refused write is really absent at the next commit, and that a commit wins over a peripheral-side write at the same edge.

// File: rtl/txn_strobe_hub.sv
module txn_strobe_hub #(
  parameter int N_CH  = 4,
  parameter int N_PER = 4,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pend_we,
  input  logic [$clog2(N_CH)-1:0]  pend_ch,
  input  logic                     pend_val,
  input  logic                     own_we,
  input  logic [$clog2(N_CH)-1:0]  own_ch,
  input  logic                     map_we,
  input  logic [$clog2(N_PER)-1:0] map_per,
  input  logic [$clog2(N_CH)-1:0]  map_ch,
  input  logic                     wsh_we,
  input  logic [$clog2(N_PER)-1:0] wsh_per,
  input  logic [DW-1:0]            wsh_data,
  input  logic                     hw_we,
  input  logic [$clog2(N_PER)-1:0] hw_per,
  input  logic [DW-1:0]            hw_data,
  input  logic [$clog2(N_PER)-1:0] rd_per,
  output logic [DW-1:0]            rd_data,
  output logic [N_PER*DW-1:0]      live_flat,
  output logic [N_CH-1:0]          pend_o,
  output logic [N_CH-1:0]          start_o,
  output logic [N_CH-1:0]          done_o,
  output logic                     fault_o
);
  localparam int CW = $clog2(N_CH);
  localparam int PW = $clog2(N_PER);

  logic [N_CH-1:0] pend_q, pend_d;
  logic [CW-1:0]   own_q;
  logic            own_vld, fault_q;
  logic [CW-1:0]   chan_all [N_PER];
  logic [DW-1:0]   rsh_all  [N_PER];
  logic            refuse;

  assign pend_o  = pend_q;
  assign start_o = pend_q & ~pend_d;
  assign done_o  = ~pend_q & pend_d;
  assign fault_o = fault_q;
  assign refuse  = own_vld && wsh_we && (chan_all[wsh_per] != own_q);
  assign rd_data = rsh_all[rd_per];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pend_d  <= '0;
      own_q   <= '0;
      own_vld <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      pend_d  <= pend_q;
      fault_q <= refuse;
      if (pend_we) pend_q[pend_ch] <= pend_val;
      if (own_we) begin
        own_q   <= own_ch;
        own_vld <= 1'b1;
      end
    end
  end

  for (genvar p = 0; p < N_PER; p++) begin : g_slot
    logic [CW-1:0] chan;
    logic [DW-1:0] live, rsh, wsh;
    logic          st, dn;

    assign st = start_o[chan];
    assign dn = done_o[chan];
    assign chan_all[p] = chan;
    assign rsh_all[p]  = rsh;
    assign live_flat[p*DW +: DW] = live;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chan <= '0;
        live <= '0;
        rsh  <= '0;
        wsh  <= '0;
      end else begin
        if (map_we && map_per == PW'(p)) chan <= map_ch;
        if (st) rsh <= live;
        if (wsh_we && wsh_per == PW'(p) && !refuse) wsh <= wsh_data;
        if (dn) live <= wsh;
        else if (hw_we && hw_per == PW'(p)) live <= hw_data;
      end
    end
  end
endmodule

module txn_strobe_hub_chk #(
  parameter int N_CH  = 4,
  parameter int N_PER = 4,
  parameter int DW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pend_we,
  input logic [$clog2(N_CH)-1:0]  pend_ch,
  input logic                     pend_val,
  input logic                     wsh_we,
  input logic                     hw_we,
  input logic [N_PER*DW-1:0]      live_flat,
  input logic [N_CH-1:0]          pend_o,
  input logic [N_CH-1:0]          start_o,
  input logic [N_CH-1:0]          done_o,
  input logic                     fault_o
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |=> ((start_o & $past(start_o)) == '0));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |=> ((done_o & $past(done_o)) == '0));

  a_r2_start_after_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && pend_val && !pend_o[pend_ch]) |=> start_o[$past(pend_ch)]);

  a_r3_done_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && !pend_val && pend_o[pend_ch]) |=> done_o[$past(pend_ch)]);

  a_r9_fault_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(wsh_we));

  a_r5_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o == '0 && !hw_we) |=> $stable(live_flat));
endmodule

bind txn_strobe_hub txn_strobe_hub_chk #(.N_CH(N_CH), .N_PER(N_PER), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_we(pend_we), .pend_ch(pend_ch), .pend_val(pend_val),
  .wsh_we(wsh_we), .hw_we(hw_we), .live_flat(live_flat), .pend_o(pend_o),
  .start_o(start_o), .done_o(done_o), .fault_o(fault_o));

// File: tb/txn_strobe_hub_bench.sv
module txn_strobe_hub_bench;
  localparam int NC = 4, NP = 4, DW = 8;

  logic clk = 0, rst_n = 0;
  logic pend_we = 0, pend_val = 0, own_we = 0, map_we = 0, wsh_we = 0, hw_we = 0;
  logic [1:0] pend_ch = 0, own_ch = 0, map_per = 0, map_ch = 0, wsh_per = 0, hw_per = 0, rd_per = 0;
  logic [DW-1:0] wsh_data = 0, hw_data = 0, rd_data;
  logic [NP*DW-1:0] live_flat;
  logic [NC-1:0] pend_o, start_o, done_o;
  logic fault_o;

  txn_strobe_hub #(.N_CH(NC), .N_PER(NP), .DW(DW)) u_txn_strobe_hub (
    .clk(clk), .rst_n(rst_n), .pend_we(pend_we), .pend_ch(pend_ch), .pend_val(pend_val),
    .own_we(own_we), .own_ch(own_ch), .map_we(map_we), .map_per(map_per), .map_ch(map_ch),
    .wsh_we(wsh_we), .wsh_per(wsh_per), .wsh_data(wsh_data), .hw_we(hw_we), .hw_per(hw_per),
    .hw_data(hw_data), .rd_per(rd_per), .rd_data(rd_data), .live_flat(live_flat),
    .pend_o(pend_o), .start_o(start_o), .done_o(done_o), .fault_o(fault_o));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int txm[NP], livem[NP], rshm[NP], wshm[NP];
  bit pm[NC];
  bit curv = 0;
  int curc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int p = 0; p < NP; p++) begin
      chk(int'(live_flat[p*DW +: DW]) == livem[p], req, int'(live_flat[p*DW +: DW]), livem[p]);
      rd_per = 2'(p);
      #1;
      chk(int'(rd_data) == rshm[p], req, int'(rd_data), rshm[p]);
    end
  endtask

  task automatic do_pend(input int c, input bit v);
    bit rise, fall;
    rise = v && !pm[c];
    fall = !v && pm[c];
    @(negedge clk);
    pend_we = 1; pend_ch = 2'(c); pend_val = v;
    @(negedge clk);
    pend_we = 0;
    chk(int'(start_o) == (rise ? (1 << c) : 0), "R2", int'(start_o), rise ? (1 << c) : 0);
    chk(int'(done_o) == (fall ? (1 << c) : 0), "R3", int'(done_o), fall ? (1 << c) : 0);
    pm[c] = v;
    @(negedge clk);
    chk(start_o == 0 && done_o == 0, "R2 R3 single", int'({start_o, done_o}), 0);
    for (int p = 0; p < NP; p++) begin
      if (txm[p] == c && rise) rshm[p] = livem[p];
      if (txm[p] == c && fall) livem[p] = wshm[p];
    end
    compare_all(rise ? "R4 R6" : "R5 R6");
  endtask

  task automatic do_map(input int p, input int c);
    @(negedge clk);
    map_we = 1; map_per = 2'(p); map_ch = 2'(c);
    @(negedge clk);
    map_we = 0;
    txm[p] = c;
  endtask

  task automatic do_hw(input int p, input int v);
    @(negedge clk);
    hw_we = 1; hw_per = 2'(p); hw_data = DW'(v);
    @(negedge clk);
    hw_we = 0;
    livem[p] = v;
  endtask

  task automatic do_own(input int c);
    @(negedge clk);
    own_we = 1; own_ch = 2'(c);
    @(negedge clk);
    own_we = 0;
    curv = 1; curc = c;
  endtask

  task automatic do_wsh(input int p, input int v);
    bit expf;
    expf = curv && txm[p] != curc;
    @(negedge clk);
    wsh_we = 1; wsh_per = 2'(p); wsh_data = DW'(v);
    @(negedge clk);
    wsh_we = 0;
    chk(fault_o == expf, curv ? "R9" : "R8", int'(fault_o), int'(expf));
    if (!expf) wshm[p] = v;
    @(negedge clk);
    chk(fault_o == 0, "R9 pulse", int'(fault_o), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin txm[i] = 0; livem[i] = 0; rshm[i] = 0; wshm[i] = 0; end
    for (int i = 0; i < NC; i++) pm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pend_o == 0 && start_o == 0 && done_o == 0 && fault_o == 0, "R1",
        int'({pend_o, start_o, done_o, fault_o}), 0);
    compare_all("R1");

    for (int c = 0; c < NC; c++) begin
      do_pend(c, 1); do_pend(c, 1); do_pend(c, 0); do_pend(c, 0);
    end

    for (int c = 0; c < NC; c++)
      for (int p = 0; p < NP; p++) begin
        do_map(p, c);
        do_hw(p, 16 * p + c + 1);
        do_wsh(p, 128 + 16 * p + c);
        do_pend(c, 1);
        do_hw(p, 64 + 4 * p + c);
        compare_all("R4 R7");
        do_pend(c, 0);
      end

    do_map(0, 2); do_map(1, 2); do_map(2, 2); do_map(3, 1);
    for (int p = 0; p < NP; p++) do_wsh(p, 200 + p);
    do_pend(2, 1);
    do_pend(2, 0);

    do_own(1);
    do_wsh(3, 8'h11);
    do_wsh(0, 8'h22);
    do_wsh(1, 8'h33);
    do_pend(2, 1); do_pend(2, 0);
    do_pend(1, 1); do_pend(1, 0);
    do_own(2);
    do_wsh(0, 8'h44);
    do_wsh(3, 8'h55);
    do_pend(2, 1); do_pend(2, 0);

    do_pend(2, 1);
    do_wsh(1, 8'h66);
    @(negedge clk);
    pend_we = 1; pend_ch = 2; pend_val = 0;
    @(negedge clk);
    pend_we = 0;
    hw_we = 1; hw_per = 1; hw_data = 8'h77;
    @(negedge clk);
    hw_we = 0;
    pm[2] = 0;
    livem[1] = 8'h66;
    for (int p = 0; p < NP; p++)
      if (txm[p] == 2) livem[p] = wshm[p];
    chk(int'(live_flat[1*DW +: DW]) == 8'h66, "R10", int'(live_flat[1*DW +: DW]), 8'h66);
    compare_all("R10");
    do_hw(3, 8'h99);
    compare_all("R10");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule